// File: doc/BRIEF.md
# Hysteresis C-Element With Asymmetric Inputs

This block is a clock-sampled model of a Muller-style C-element. It is meant for synchronous simulation and for emulation of asynchronous handshake logic. The inputs fall into three groups. Symmetric inputs take part in both output transitions. Plus inputs gate only the rise to 1. Minus inputs gate only the fall to 0. In every input combination that neither raises nor lowers it, the output keeps its value. This memory is the hysteresis that lets the element join several independent handshake events.

A mode input picks how the symmetric group votes. In all-agree mode the group requests a rise only when every symmetric input is high, and a fall only when every one is low. In majority mode a strict majority of ones requests a rise, a strict majority of zeros requests a fall, and an exact tie requests nothing. When the symmetric group has an odd width no tie can occur, so the block always uses the all-agree rule. A group width of zero removes the plus or minus group, which leaves the plain symmetric element. The output register updates on each rising clock edge and clears to 0 on an asynchronous active-low reset.

Top module: `cel_hyst_celement`

## Requirements
- R1: While rst_ni is low, out_o is 0. This holds from the first instant of reset, with no clock edge needed.
- R2: In all-agree mode (mode_i = 0), when every sym_i bit and every plus_i bit is high at a rising edge, out_o is 1 after that edge, whatever minus_i is.
- R3: In all-agree mode, when every sym_i bit and every minus_i bit is low at a rising edge, out_o is 0 after that edge, whatever plus_i is.
- R4: In all-agree mode, when the sym_i bits are not all equal, out_o keeps its value across the edge. This holds with the output at 0 and with the output at 1.
- R5: In majority mode (mode_i = 1) with an even sym_i width, more ones than zeros in sym_i together with all plus_i high sets out_o. More zeros than ones together with all minus_i low clears out_o.
- R6: In majority mode, when sym_i holds exactly as many ones as zeros, out_o keeps its value in both output states.
- R7: plus_i has no effect on a fall. A fall occurs with any plus_i value once its symmetric and minus conditions hold.
- R8: minus_i has no effect on a rise. A rise occurs with any minus_i value once its symmetric and plus conditions hold.
- R9: While out_o is 1, any minus_i bit that is high keeps out_o at 1, even when every sym_i bit is low.
- R10: While out_o is 0, any plus_i bit that is low keeps out_o at 0, even when every sym_i bit is high.
- R11: With an odd N_SYM, majority mode behaves exactly like all-agree mode: a bare majority of ones or of zeros holds the output.
- R12: With N_PLUS = 0, the plus_i port is ignored and a rise needs only the symmetric condition. N_MINUS = 0 has the same effect on the fall side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, clears out_o |
| mode_i | input | 1 | Vote rule: 0 all-agree, 1 majority with tie-hold |
| sym_i | input | N_SYM | Symmetric inputs, used in both transitions |
| plus_i | input | max(N_PLUS,1) | Rise-only inputs, all must be high to rise |
| minus_i | input | max(N_MINUS,1) | Fall-only inputs, all must be low to fall |
| out_o | output | 1 | Registered element state |

## Verification
The block's only state is out_o, so a wrong next-state decision shows up at the port one clock edge after the inputs that triggered it. The bench keeps a reference state of its own. It compares out_o against that state after every edge, so a missed hold, a spurious rise or a lost fall is caught in that same cycle. Hold cases are driven deliberately from both output states, because an error that only loses the stored value stays invisible when the output already matches the input vote.

// File: rtl/cel_pkg.sv
package cel_pkg;
  typedef enum logic {
    MODE_ALL = 1'b0,
    MODE_MAJ = 1'b1
  } cel_mode_e;
endpackage

// File: rtl/cel_sym_vote.sv
module cel_sym_vote #(
  parameter int N_SYM = 4
) (
  input  logic [N_SYM-1:0]     sym_i,
  input  cel_pkg::cel_mode_e   mode_i,
  output logic                 up_o,
  output logic                 down_o
);
  logic all_hi, all_lo;
  assign all_hi = &sym_i;
  assign all_lo = ~|sym_i;

  generate
    if (N_SYM % 2 == 1) begin : g_odd
      // no tie possible: strict rule keeps hysteresis
      logic unused_mode;
      assign unused_mode = mode_i;
      assign up_o   = all_hi;
      assign down_o = all_lo;
    end else begin : g_even
      localparam int CW = $clog2(N_SYM + 1);
      logic [CW-1:0] ones;
      logic [CW:0]   twice;
      always_comb begin
        ones = '0;
        for (int i = 0; i < N_SYM; i++) ones = ones + CW'(sym_i[i]);
      end
      assign twice = {ones, 1'b0};
      always_comb begin
        if (mode_i == cel_pkg::MODE_MAJ) begin
          up_o   = twice > (CW+1)'(N_SYM);
          down_o = twice < (CW+1)'(N_SYM);
        end else begin
          up_o   = all_hi;
          down_o = all_lo;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/cel_gate_group.sv
module cel_gate_group #(
  parameter int N      = 2,
  parameter bit NEED_HI = 1'b1,
  localparam int W     = (N > 0) ? N : 1
) (
  input  logic [W-1:0] grp_i,
  output logic         permit_o
);
  generate
    if (N == 0) begin : g_none
      logic unused_grp;
      assign unused_grp = ^grp_i;
      assign permit_o = 1'b1;
    end else if (NEED_HI) begin : g_hi
      assign permit_o = &grp_i;
    end else begin : g_lo
      assign permit_o = ~|grp_i;
    end
  endgenerate
endmodule

// File: rtl/cel_hyst_celement.sv
module cel_hyst_celement #(
  parameter int N_SYM   = 4,
  parameter int N_PLUS  = 2,
  parameter int N_MINUS = 2,
  localparam int PW = (N_PLUS  > 0) ? N_PLUS  : 1,
  localparam int MW = (N_MINUS > 0) ? N_MINUS : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic [N_SYM-1:0] sym_i,
  input  logic [PW-1:0]    plus_i,
  input  logic [MW-1:0]    minus_i,
  output logic             out_o
);
  import cel_pkg::*;

  cel_mode_e mode;
  logic sym_up, sym_down, plus_ok, minus_ok;
  logic rise, fall, q_d, q_q;

  assign mode = cel_mode_e'(mode_i);

  cel_sym_vote #(.N_SYM(N_SYM)) u_vote (
    .sym_i (sym_i),
    .mode_i(mode),
    .up_o  (sym_up),
    .down_o(sym_down)
  );

  cel_gate_group #(.N(N_PLUS), .NEED_HI(1'b1)) u_plus (
    .grp_i   (plus_i),
    .permit_o(plus_ok)
  );

  cel_gate_group #(.N(N_MINUS), .NEED_HI(1'b0)) u_minus (
    .grp_i   (minus_i),
    .permit_o(minus_ok)
  );

  assign rise = sym_up & plus_ok;
  assign fall = sym_down & minus_ok;

  always_comb begin
    q_d = q_q;
    if (!q_q && rise)     q_d = 1'b1;
    else if (q_q && fall) q_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= q_d;
  end

  assign out_o = q_q;

  a_r4_split_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_ALL && !(&sym_i) && (|sym_i)) |=> $stable(out_o));

  a_r11_odd_strict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((N_SYM % 2 == 1) && !(&sym_i) && (|sym_i)) |=> $stable(out_o));

  a_r6_tie_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_MAJ && $countones(sym_i) * 2 == N_SYM) |=> $stable(out_o));

  generate
    if (N_PLUS > 0) begin : g_a_plus
      a_r10_plus_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!out_o && !(&plus_i)) |=> !out_o);
      a_r2_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((&sym_i) && (&plus_i)) |=> out_o);
    end
    if (N_MINUS > 0) begin : g_a_minus
      a_r9_minus_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_o && (|minus_i)) |=> out_o);
      a_r3_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(|sym_i) && !(|minus_i)) |=> !out_o);
    end
  endgenerate
endmodule

// File: tb/cel_hyst_celement_bench.sv
`timescale 1ns/1ps
module cel_hyst_celement_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0;
  logic [3:0] sym = '0;
  logic [1:0] plus = '0;
  logic [1:0] minus = '0;
  logic       out_a, out_b;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct { logic ea; logic eb; string tag; } item_t;
  item_t q[$];
  logic ref_a = 1'b0, ref_b = 1'b0;

  always #2.5 clk = ~clk;

  cel_hyst_celement u_cel_hyst_celement (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .sym_i(sym), .plus_i(plus), .minus_i(minus), .out_o(out_a));

  // odd symmetric width, no plus group, one minus input
  cel_hyst_celement #(.N_SYM(3), .N_PLUS(0), .N_MINUS(1)) u_cel_hyst_celement_odd (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .sym_i(sym[2:0]), .plus_i(plus[0]), .minus_i(minus[0]), .out_o(out_b));

  function automatic logic model(logic prev, logic md, int n, int ones,
                                 logic p_ok, logic m_ok);
    logic up, dn;
    if (md == 1'b0 || (n % 2) == 1) begin
      up = (ones == n); dn = (ones == 0);
    end else begin
      up = (2 * ones > n); dn = (2 * ones < n);
    end
    if (!prev && up && p_ok) return 1'b1;
    if (prev && dn && m_ok) return 1'b0;
    return prev;
  endfunction

  task automatic check(logic act, logic exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(logic md, logic [3:0] s, logic [1:0] p, logic [1:0] m, string tag);
    item_t it;
    @(negedge clk);
    mode = md; sym = s; plus = p; minus = m;
    ref_a = model(ref_a, md, 4, $countones(s), &p, ~|m);
    ref_b = model(ref_b, md, 3, $countones(s[2:0]), 1'b1, ~m[0]);
    it.ea = ref_a; it.eb = ref_b; it.tag = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(out_a, it.ea, it.tag);
      check(out_b, it.eb, {it.tag, " odd"});
    end
  end

  initial begin
    #1;
    check(out_a, 1'b0, "R1 reset");
    check(out_b, 1'b0, "R1 reset odd");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // all-agree mode
    step(0, 4'b1111, 2'b11, 2'b11, "R2 R8 rise minus high");
    step(0, 4'b0110, 2'b00, 2'b00, "R4 split hold at 1");
    step(0, 4'b0000, 2'b01, 2'b11, "R9 minus keeps 1");
    step(0, 4'b0000, 2'b10, 2'b01, "R9 one minus keeps 1");
    step(0, 4'b0000, 2'b10, 2'b00, "R3 R7 fall plus mixed");
    step(0, 4'b1011, 2'b11, 2'b00, "R4 split hold at 0");
    step(0, 4'b1111, 2'b01, 2'b00, "R10 plus low blocks");
    step(0, 4'b1111, 2'b11, 2'b10, "R2 rise");
    step(0, 4'b0000, 2'b11, 2'b00, "R3 R7 fall plus high");
    // majority mode
    step(1, 4'b0011, 2'b11, 2'b00, "R6 tie hold at 0");
    step(1, 4'b1011, 2'b11, 2'b01, "R5 R11 majority rise");
    step(1, 4'b0101, 2'b00, 2'b00, "R6 tie hold at 1");
    step(1, 4'b0001, 2'b00, 2'b10, "R9 majority minus keeps");
    step(1, 4'b0100, 2'b11, 2'b00, "R5 R11 majority fall");
    step(1, 4'b0111, 2'b10, 2'b00, "R10 majority plus blocks");
    step(1, 4'b0111, 2'b00, 2'b00, "R12 odd rise no plus");
    step(1, 4'b1110, 2'b11, 2'b00, "R5 rise again");
    step(1, 4'b0000, 2'b00, 2'b00, "R3 fall all low");
    for (int i = 0; i < 800; i++)
      step($urandom_range(0, 1), 4'($urandom), 2'($urandom), 2'($urandom), "R2-random");
    @(negedge clk);
    @(negedge clk);
    // asynchronous reset from state 1
    step(0, 4'b1111, 2'b11, 2'b00, "R2 pre-reset rise");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(out_a, 1'b0, "R1 async reset");
    check(out_b, 1'b0, "R1 async reset odd");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule